// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec, 8-bit Data

This block guards a data word held in memory with a Hamming single-error-correcting code. The encoder path turns an 8-bit word into a 12-bit codeword, ready to be written to storage. Four parity bits sit at the power-of-two positions of that codeword and the data bits fill the remaining positions. The decoder path takes a 12-bit word read back from storage and computes the parity again. Comparing the recomputed parity with the stored parity gives a 4-bit syndrome. Because of the way the bits are placed, that syndrome is the 1-based position of a single flipped bit.

The decoder inverts the bit the syndrome points to and returns the repaired data. It also returns two status flags and the raw syndrome, which can be written to an error log. A syndrome that points past the last codeword position cannot come from a single flip, so the decoder reports it as uncorrectable.

Both paths are combinational. A parameter `OUT_REG`, on by default, adds one register stage after each path. The data width is a parameter, and the number of check bits is derived from it.

Top module: `hsec_codec`

## Requirements
- R1: The codeword bit at index p-1 holds position p. Check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: Check bit k (position 2^k) is the even parity of every data bit whose position number has bit k set.
- R3: If the decoder input is a valid codeword, the syndrome is 0, both flags are 0, and the output data equals the encoded data.
- R4: If one data-position bit of a valid codeword is inverted, the syndrome equals that position. The corrected flag is 1, the uncorrectable flag is 0, and the output data equals the original data.
- R5: If one check-position bit (1, 2, 4 or 8) is inverted, the syndrome equals that position and the corrected flag is 1. The output data equals the data bits as read, which are the original data.
- R6: If the syndrome is 13, 14 or 15, the uncorrectable flag is 1 and the corrected flag is 0. The output data is the data bits exactly as read, with no bit inverted.
- R7: With `OUT_REG`=1, each output reflects the inputs present at the previous rising clock edge. While `rst_n` is low, every output is 0.
- R8: The corrected flag and the uncorrectable flag are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| enc_data_i | input | 8 | Data word to encode |
| enc_code_o | output | 12 | Encoded codeword; bit p-1 holds position p |
| dec_code_i | input | 12 | Codeword read back from storage |
| dec_data_o | output | 8 | Repaired data word |
| dec_corrected_o | output | 1 | Syndrome named a valid position and that bit was inverted |
| dec_uncorr_o | output | 1 | Syndrome beyond the codeword length |
| dec_syndrome_o | output | 4 | Raw syndrome, for logging |

## Verification
A fault in the parity masks or in the bit placement shows as a wrong codeword, or as a nonzero syndrome on a clean word. It appears in the very next registered output, for most data values. A wrong flip decode inverts the wrong data bit, or misses one, and only for the positions that share the faulty term. For that reason every one of the 12 single-bit flips is applied to all 256 data values. The three syndromes above 12 are produced deliberately with paired flips, so a fault in the range decode shows as a wrong flag or as data that was changed when it should have been left as read.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

   localparam int MAX_DATA_W = 57;

   // Smallest k with 2^k - 1 >= m + k
   function automatic int chk_bits(input int m);
      int k;
      k = 1;
      while (((1 << k) - 1) < (m + k)) k++;
      return k;
   endfunction

   function automatic bit is_pow2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // 1-based codeword position of data bit idx
   function automatic int data_pos(input int idx);
      int n;
      int p;
      n = 0;
      p = 0;
      for (int q = 1; q < 128; q++) begin
         if (!is_pow2(q) && (p == 0)) begin
            if (n == idx) p = q;
            n++;
         end
      end
      return p;
   endfunction

   // Data index held at a non-power-of-two position
   function automatic int data_idx(input int pos);
      int n;
      n = 0;
      for (int q = 1; q < pos; q++) begin
         if (!is_pow2(q)) n++;
      end
      return n;
   endfunction

   // Data bits covered by check bit k
   function automatic logic [63:0] cover_mask(input int k, input int dw);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < dw; i++) begin
         if (((data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/hsec_parity.sv
module hsec_parity #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);
   for (genvar k = 0; k < CHK_W; k++) begin : g_chk
      localparam logic [63:0] MASK = hsec_pkg::cover_mask(k, DATA_W);
      assign chk_o[k] = ^(data_i & MASK[DATA_W-1:0]);
   end
endmodule

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   parameter int CW     = 12
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CW-1:0]     code_o
);
   logic [CHK_W-1:0] chk;

   hsec_parity #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_par (
      .data_i (data_i),
      .chk_o  (chk)
   );

   for (genvar p = 1; p <= CW; p++) begin : g_pos
      if (hsec_pkg::is_pow2(p)) begin : g_c
         assign code_o[p-1] = chk[$clog2(p)];
      end else begin : g_d
         localparam int DI = hsec_pkg::data_idx(p);
         assign code_o[p-1] = data_i[DI];
      end
   end
endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   parameter int CW     = 12
) (
   input  logic [CW-1:0]     code_i,
   output logic [DATA_W-1:0] raw_o,
   output logic [CHK_W-1:0]  syn_o
);
   logic [CHK_W-1:0] stored;
   logic [CHK_W-1:0] recalc;

   for (genvar i = 0; i < DATA_W; i++) begin : g_raw
      localparam int DP = hsec_pkg::data_pos(i);
      assign raw_o[i] = code_i[DP-1];
   end

   for (genvar k = 0; k < CHK_W; k++) begin : g_st
      assign stored[k] = code_i[(1 << k) - 1];
   end

   hsec_parity #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_par (
      .data_i (raw_o),
      .chk_o  (recalc)
   );

   assign syn_o = stored ^ recalc;
endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   parameter int CW     = 12
) (
   input  logic [CW-1:0]     code_i,
   input  logic [CHK_W-1:0]  syn_i,
   output logic [DATA_W-1:0] data_o,
   output logic              corr_o,
   output logic              uncorr_o
);
   logic [CW-1:0] flip;
   logic [CW-1:0] fixed;

   for (genvar p = 1; p <= CW; p++) begin : g_flip
      localparam logic [CHK_W-1:0] PV = CHK_W'(p);
      assign flip[p-1] = (syn_i == PV);
   end

   assign fixed = code_i ^ flip;

   for (genvar i = 0; i < DATA_W; i++) begin : g_out
      localparam int DP = hsec_pkg::data_pos(i);
      assign data_o[i] = fixed[DP-1];
   end

   assign corr_o   = |flip;
   assign uncorr_o = (|syn_i) & ~(|flip);
endmodule

// File: rtl/hsec_pipe.sv
module hsec_pipe #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (EN) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o <= '0;
         else        q_o <= d_i;
      end
   end else begin : g_wire
      assign q_o = d_i;
   end
endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int CHK_W  = hsec_pkg::chk_bits(DATA_W),
   localparam int CW     = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CW-1:0]     enc_code_o,
   input  logic [CW-1:0]     dec_code_i,
   output logic [DATA_W-1:0] dec_data_o,
   output logic              dec_corrected_o,
   output logic              dec_uncorr_o,
   output logic [CHK_W-1:0]  dec_syndrome_o
);
   localparam int DEC_W = DATA_W + 2 + CHK_W;

   if ((DATA_W < 1) || (DATA_W > hsec_pkg::MAX_DATA_W)) begin : g_bad_width
      $error("hsec_codec: DATA_W must lie in 1..%0d", hsec_pkg::MAX_DATA_W);
   end
   if (((1 << CHK_W) - 1) < CW) begin : g_bad_chk
      $error("hsec_codec: check width too small for codeword");
   end

   logic [CW-1:0]     enc_code_c;
   logic [DATA_W-1:0] raw_c;
   logic [CHK_W-1:0]  syn_c;
   logic [DATA_W-1:0] data_c;
   logic              corr_c;
   logic              uncorr_c;
   logic [DEC_W-1:0]  dec_q;

   hsec_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW(CW)) u_enc (
      .data_i (enc_data_i),
      .code_o (enc_code_c)
   );

   hsec_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW(CW)) u_syn (
      .code_i (dec_code_i),
      .raw_o  (raw_c),
      .syn_o  (syn_c)
   );

   hsec_corrector #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW(CW)) u_cor (
      .code_i   (dec_code_i),
      .syn_i    (syn_c),
      .data_o   (data_c),
      .corr_o   (corr_c),
      .uncorr_o (uncorr_c)
   );

   // Raw data equals corrected data whenever the syndrome points at a
   // check position or outside the word; the corrector output covers both.
   logic unused_raw;
   assign unused_raw = ^raw_c;

   hsec_pipe #(.W(CW), .EN(OUT_REG)) u_enc_q (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (enc_code_c),
      .q_o   (enc_code_o)
   );

   hsec_pipe #(.W(DEC_W), .EN(OUT_REG)) u_dec_q (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({data_c, corr_c, uncorr_c, syn_c}),
      .q_o   (dec_q)
   );

   assign {dec_data_o, dec_corrected_o, dec_uncorr_o, dec_syndrome_o} = dec_q;
endmodule

// File: rtl/hsec_codec_chk.sv
module hsec_codec_chk #(
   parameter int DATA_W  = 8,
   parameter int CHK_W   = 4,
   parameter int CW      = 12,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CW-1:0]     enc_code_o,
   input logic [DATA_W-1:0] dec_data_o,
   input logic              dec_corrected_o,
   input logic              dec_uncorr_o,
   input logic [CHK_W-1:0]  dec_syndrome_o
);
   localparam logic [CHK_W-1:0] LAST = CHK_W'(CW);

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_corrected_o && dec_uncorr_o)); // R8

   AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_syndrome_o == '0) |-> (!dec_corrected_o && !dec_uncorr_o)); // R3

   AST_POSITION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      ((dec_syndrome_o != '0) && (dec_syndrome_o <= LAST)) |-> dec_corrected_o); // R4

   AST_BEYOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_syndrome_o > LAST) |-> (dec_uncorr_o && !dec_corrected_o)); // R6

   if (OUT_REG) begin : g_rst_chk
      AST_RESET_CLEARS: assert property (@(posedge clk)
         !rst_n |=> ((enc_code_o == '0) && (dec_data_o == '0) &&
                     !dec_corrected_o && !dec_uncorr_o && (dec_syndrome_o == '0))); // R7
   end
endmodule

bind hsec_codec hsec_codec_chk #(
   .DATA_W  (DATA_W),
   .CHK_W   (CHK_W),
   .CW      (CW),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .enc_code_o      (enc_code_o),
   .dec_data_o      (dec_data_o),
   .dec_corrected_o (dec_corrected_o),
   .dec_uncorr_o    (dec_uncorr_o),
   .dec_syndrome_o  (dec_syndrome_o)
);

// File: tb/hsec_codec_test.sv
module hsec_codec_test;
   localparam int POS [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

   typedef struct {
      logic [11:0] enc;
      logic [7:0]  data;
      logic        corr;
      logic        uncorr;
      logic [3:0]  syn;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  enc_data = '0;
   logic [11:0] dec_code = '0;
   logic [11:0] enc_code_o;
   logic [7:0]  dec_data_o;
   logic        dec_corrected_o;
   logic        dec_uncorr_o;
   logic [3:0]  dec_syndrome_o;

   int   n_vec = 0;
   int   n_bad = 0;
   exp_t sb [$];

   always #2.5 clk = ~clk;

   hsec_codec uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .enc_data_i      (enc_data),
      .enc_code_o      (enc_code_o),
      .dec_code_i      (dec_code),
      .dec_data_o      (dec_data_o),
      .dec_corrected_o (dec_corrected_o),
      .dec_uncorr_o    (dec_uncorr_o),
      .dec_syndrome_o  (dec_syndrome_o)
   );

   // Placement and parity from R1/R2
   function automatic logic [11:0] model_enc(input logic [7:0] d);
      logic [11:0] c;
      logic        par;
      c = '0;
      for (int i = 0; i < 8; i++) c[POS[i]-1] = d[i];
      for (int k = 0; k < 4; k++) begin
         par = 1'b0;
         for (int i = 0; i < 8; i++) if (((POS[i] >> k) & 1) == 1) par ^= d[i];
         c[(1 << k) - 1] = par;
      end
      return c;
   endfunction

   function automatic logic [7:0] model_raw(input logic [11:0] c);
      logic [7:0] d;
      for (int i = 0; i < 8; i++) d[i] = c[POS[i]-1];
      return d;
   endfunction

   task automatic drive(input logic [7:0] ed, input logic [11:0] dc,
                        input logic [7:0] xd, input logic xc, input logic xu,
                        input logic [3:0] xs, input string tag);
      exp_t e;
      @(negedge clk);
      enc_data = ed;
      dec_code = dc;
      e.enc = model_enc(ed);
      e.data = xd;
      e.corr = xc;
      e.uncorr = xu;
      e.syn = xs;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: outputs registered at the edge after the drive (R7)
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (enc_code_o !== e.enc || dec_data_o !== e.data ||
                dec_corrected_o !== e.corr || dec_uncorr_o !== e.uncorr ||
                dec_syndrome_o !== e.syn) begin
               n_bad++;
               $display("FAIL %s: got enc=%h data=%h corr=%b unc=%b syn=%0d, expected enc=%h data=%h corr=%b unc=%b syn=%0d",
                        e.tag, enc_code_o, dec_data_o, dec_corrected_o, dec_uncorr_o,
                        dec_syndrome_o, e.enc, e.data, e.corr, e.uncorr, e.syn);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got no end, expected end before 100000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [11:0] cw;
      logic [11:0] bad;
      // R7: reset state, inputs nonzero
      enc_data = 8'hA5;
      dec_code = 12'hFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (enc_code_o !== '0 || dec_data_o !== '0 || dec_corrected_o !== 1'b0 ||
          dec_uncorr_o !== 1'b0 || dec_syndrome_o !== '0) begin
         n_bad++;
         $display("FAIL R7 reset: got enc=%h data=%h corr=%b unc=%b syn=%0d, expected all zero",
                  enc_code_o, dec_data_o, dec_corrected_o, dec_uncorr_o, dec_syndrome_o);
      end
      rst_n = 1'b1;

      // R1 R2 R3: clean round trip for every data value
      for (int d = 0; d < 256; d++) begin
         cw = model_enc(8'(d));
         drive(8'(d), cw, 8'(d), 1'b0, 1'b0, 4'd0, "R1 R2 R3 clean");
      end

      // R4 R5: every single flip on every data value
      for (int d = 0; d < 256; d++) begin
         cw = model_enc(8'(d));
         for (int b = 0; b < 12; b++) begin
            bad = cw ^ (12'd1 << b);
            if (((b + 1) & b) == 0)
               drive(8'(255 - d), bad, 8'(d), 1'b1, 1'b0, 4'(b + 1), "R5 check flip");
            else
               drive(8'(255 - d), bad, 8'(d), 1'b1, 1'b0, 4'(b + 1), "R4 data flip");
         end
      end

      // R6 R8: paired flips giving syndromes 13, 14, 15
      for (int d = 0; d < 256; d += 5) begin
         cw = model_enc(8'(d));
         for (int lo = 1; lo <= 3; lo++) begin
            bad = cw ^ (12'd1 << 11) ^ (12'd1 << (lo - 1));
            drive(8'(d), bad, model_raw(bad), 1'b0, 1'b1, 4'(12 ^ lo), "R6 R8 beyond word");
         end
      end

      while (sb.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule